// File: doc/BRIEF.md
# Phase-Accumulator Wavetable Oscillator

This block is a numerically controlled oscillator that plays a waveform stored in a small internal table. A fixed-point phase register grows by a programmable step on every clock. The whole-number bits of that phase select one table entry, and the selected entry is registered and driven out as the sample. The output frequency is the clock frequency times the step (counted in table entries) divided by the number of entries. Tuning is therefore a single register value and needs no clock divider.

A signed modulation term is added to the programmed step before it reaches the accumulator. This lets a second source bend the pitch without touching the base tuning. The summed step is saturated to a floor of zero and to a ceiling set by a mode pin. The narrow ceiling allows one table entry per clock, which keeps every stored harmonic below the folding point. The wide ceiling allows half the table per clock, which reaches half the clock rate. A separate write port fills the table.

Top module: `wt_nco`

## Requirements
- R1: A synchronous `rst` held high across a rising edge sets the phase to 0, so `rd_addr_o` reads 0. The same edge sets `sample_o` to 0.
- R2: On every rising edge without reset, exactly one addition is made: phase becomes (phase + step) modulo 2^PHASE_W. There is no overflow flag, so the address wraps from the last entry back to entry 0.
- R3: `rd_addr_o` equals the upper PHASE_W−FRAC_W bits of the phase, i.e. phase shifted right by FRAC_W (bit positions FRAC_W and up).
- R4: The step is `inc_i` (unsigned) plus `mod_i` (two's complement) whenever that sum lies between 0 and the active ceiling.
- R5: When `inc_i` + `mod_i` is negative, the step is 0 and the phase holds.
- R6: With `wide_mode` = 0, the step is capped at 2^FRAC_W, which is one table entry per clock.
- R7: With `wide_mode` = 1, the step is capped at 2^(PHASE_W−1), which is half the table length per clock.
- R8: `sample_o` after a rising edge equals the table entry addressed by `rd_addr_o` before that edge, as the entry stood before that edge. A write to that entry on the same edge yields the old data.
- R9: With `wr_en` high at a rising edge, entry `wr_addr` takes `wr_data`. This holds in reset as well. Later reads of that entry return the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wide_mode | input | 1 | 0: step ceiling of one entry; 1: step ceiling of half the table |
| inc_i | input | PHASE_W | Programmed phase step, unsigned fixed point with FRAC_W fraction bits |
| mod_i | input | MOD_W | Signed modulation added to the step |
| wr_en | input | 1 | Table write enable |
| wr_addr | input | PHASE_W−FRAC_W | Table entry to write |
| wr_data | input | SAMPLE_W | Value to write |
| rd_addr_o | output | PHASE_W−FRAC_W | Integer part of the current phase (table read address) |
| sample_o | output | SAMPLE_W | Registered table sample |

## Verification
The step inputs take effect on the rising edge that follows them, so the address moves one cycle after a step change. The sample then trails that address by one more registered cycle. A table write becomes visible in the sample two edges after it is presented, or later if the entry is not being read. The bench drives every input at the falling edge and compares both outputs at the next falling edge. It compares them against a behavioural model that is advanced at the rising edge. The one- and two-cycle delays are therefore counted into the model rather than guessed at the moment of sampling. The targeted checks measure address movement over a known number of falling edges.

// File: rtl/wt_nco_pkg.sv
package wt_nco_pkg;

   typedef enum logic {
      STEP_NARROW = 1'b0,
      STEP_WIDE   = 1'b1
   } step_mode_e;

endpackage

// File: rtl/wt_nco_step.sv
module wt_nco_step
   import wt_nco_pkg::*;
#(
   parameter int PHASE_W = 20,
   parameter int FRAC_W  = 12,
   parameter int MOD_W   = 16,
   parameter bit MOD_EN  = 1'b1
) (
   input  logic [PHASE_W-1:0] inc_i,
   input  logic [MOD_W-1:0]   mod_i,
   input  step_mode_e         mode_i,
   output logic [PHASE_W-1:0] step_o
);
   localparam int SUM_W = ((MOD_W > PHASE_W) ? MOD_W : PHASE_W) + 2;
   localparam logic signed [SUM_W-1:0] CAP_ONE  = SUM_W'(1) <<< FRAC_W;
   localparam logic signed [SUM_W-1:0] CAP_HALF = SUM_W'(1) <<< (PHASE_W - 1);

   logic signed [SUM_W-1:0] inc_ext, mod_ext, sum, cap;

   assign inc_ext = $signed({{(SUM_W-PHASE_W){1'b0}}, inc_i});

   // modulation adder present or removed by parameter
   generate
      if (MOD_EN) begin : g_mod
         assign mod_ext = $signed({{(SUM_W-MOD_W){mod_i[MOD_W-1]}}, mod_i});
      end else begin : g_nomod
         logic unused_mod;
         assign unused_mod = ^mod_i;
         assign mod_ext    = '0;
      end
   endgenerate

   assign cap = (mode_i == STEP_WIDE) ? CAP_HALF : CAP_ONE;

   always_comb begin
      sum = inc_ext + mod_ext;
      if (sum < 0)
         step_o = '0;
      else if (sum > cap)
         step_o = PHASE_W'(cap);
      else
         step_o = PHASE_W'(sum);
   end

endmodule

// File: rtl/wt_nco_phase.sv
module wt_nco_phase #(
   parameter int PHASE_W = 20
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [PHASE_W-1:0] step_i,
   output logic [PHASE_W-1:0] phase_o
);

   always_ff @(posedge clk) begin
      if (rst)
         phase_o <= '0;
      else
         phase_o <= phase_o + step_i;
   end

endmodule

// File: rtl/wt_nco_table.sv
module wt_nco_table #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en)
         mem[wr_addr] <= wr_data;
   end

   // read sees the content before any write on the same edge
   always_ff @(posedge clk) begin
      if (rst)
         rd_data <= '0;
      else
         rd_data <= mem[rd_addr];
   end

endmodule

// File: rtl/wt_nco.sv
module wt_nco
   import wt_nco_pkg::*;
#(
   parameter int  PHASE_W  = 20,
   parameter int  FRAC_W   = 12,
   parameter int  SAMPLE_W = 16,
   parameter int  MOD_W    = 16,
   parameter bit  MOD_EN   = 1'b1,
   localparam int ADDR_W   = PHASE_W - FRAC_W
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                wide_mode,
   input  logic [PHASE_W-1:0]  inc_i,
   input  logic [MOD_W-1:0]    mod_i,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   wr_addr,
   input  logic [SAMPLE_W-1:0] wr_data,
   output logic [ADDR_W-1:0]   rd_addr_o,
   output logic [SAMPLE_W-1:0] sample_o
);

   generate
      if (FRAC_W < 1) begin : g_bad_frac
         $error("wt_nco: FRAC_W must be at least 1");
      end
      if (ADDR_W < 2 || ADDR_W > 12) begin : g_bad_addr
         $error("wt_nco: PHASE_W-FRAC_W must lie in 2..12");
      end
      if (MOD_W < 2 || SAMPLE_W < 1) begin : g_bad_width
         $error("wt_nco: MOD_W must be >= 2 and SAMPLE_W >= 1");
      end
   endgenerate

   logic [PHASE_W-1:0] step_w;
   logic [PHASE_W-1:0] phase_q;

   wt_nco_step #(
      .PHASE_W (PHASE_W),
      .FRAC_W  (FRAC_W),
      .MOD_W   (MOD_W),
      .MOD_EN  (MOD_EN)
   ) u_step (
      .inc_i  (inc_i),
      .mod_i  (mod_i),
      .mode_i (step_mode_e'(wide_mode)),
      .step_o (step_w)
   );

   wt_nco_phase #(
      .PHASE_W (PHASE_W)
   ) u_phase (
      .clk     (clk),
      .rst     (rst),
      .step_i  (step_w),
      .phase_o (phase_q)
   );

   assign rd_addr_o = phase_q[PHASE_W-1:FRAC_W];

   wt_nco_table #(
      .ADDR_W (ADDR_W),
      .DATA_W (SAMPLE_W)
   ) u_table (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (rd_addr_o),
      .rd_data (sample_o)
   );

endmodule

// File: rtl/wt_nco_chk.sv
module wt_nco_chk #(
   parameter int PHASE_W  = 20,
   parameter int FRAC_W   = 12,
   parameter int SAMPLE_W = 16,
   parameter int MOD_W    = 16
) (
   input logic                clk,
   input logic                rst,
   input logic                wide_mode,
   input logic [PHASE_W-1:0]  inc_i,
   input logic [MOD_W-1:0]    mod_i,
   input logic [PHASE_W-1:0]  step,
   input logic [PHASE_W-1:0]  phase,
   input logic [SAMPLE_W-1:0] sample
);
   localparam logic [PHASE_W-1:0] CAP_ONE  = PHASE_W'(1) << FRAC_W;
   localparam logic [PHASE_W-1:0] CAP_HALF = PHASE_W'(1) << (PHASE_W - 1);

   logic rst_d = 1'b0;

   always @(posedge clk) begin
      if (rst_d) begin
         // R1: state cleared by the previous reset edge
         assert_reset_clear_R1: assert (phase == '0 && sample == '0)
            else $error("R1: phase or sample not cleared after reset");
      end
      rst_d <= rst;
   end

   assert_one_add_R2: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> phase == PHASE_W'($past(phase) + $past(step)));

   assert_floor_R5: assert property (@(posedge clk) disable iff (rst)
      (inc_i == '0 && mod_i[MOD_W-1]) |-> step == '0);

   assert_cap_narrow_R6: assert property (@(posedge clk) disable iff (rst)
      !wide_mode |-> step <= CAP_ONE);

   assert_cap_wide_R7: assert property (@(posedge clk) disable iff (rst)
      wide_mode |-> step <= CAP_HALF);

endmodule

bind wt_nco wt_nco_chk #(
   .PHASE_W  (PHASE_W),
   .FRAC_W   (FRAC_W),
   .SAMPLE_W (SAMPLE_W),
   .MOD_W    (MOD_W)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .wide_mode (wide_mode),
   .inc_i     (inc_i),
   .mod_i     (mod_i),
   .step      (step_w),
   .phase     (phase_q),
   .sample    (sample_o)
);

// File: tb/test_wt_nco.sv
module test_wt_nco;
   localparam int PW = 20;
   localparam int FW = 12;
   localparam int AW = PW - FW;
   localparam int N  = 1 << AW;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          wide_mode = 1'b0;
   logic [PW-1:0] inc_i = '0;
   logic [15:0]   mod_i = '0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [15:0]   wr_data = '0;
   logic [AW-1:0] rd_addr_o;
   logic [15:0]   sample_o;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;

   always #5 clk = ~clk;

   wt_nco i_wt_nco (
      .clk(clk), .rst(rst), .wide_mode(wide_mode), .inc_i(inc_i), .mod_i(mod_i),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr_o(rd_addr_o), .sample_o(sample_o)
   );

   // behavioural reference model
   int unsigned m_phase = 0;
   logic [15:0] m_sample = '0;
   bit          m_sknown = 1'b0;
   logic [15:0] m_tab [N];
   bit          m_known [N];

   function automatic int unsigned ref_step(int unsigned inc, int modv, bit wide);
      longint s, cap;
      s   = longint'(inc) + longint'(modv);
      cap = wide ? (longint'(1) << (PW - 1)) : (longint'(1) << FW);
      if (s < 0) s = 0;
      if (s > cap) s = cap;
      return int'(s);
   endfunction

   always @(posedge clk) begin
      int a;
      a = int'(m_phase >> FW);
      if (rst) begin
         m_phase  = 0;
         m_sample = '0;
         m_sknown = 1'b1;
      end else begin
         m_sample = m_tab[a];
         m_sknown = m_known[a];
         m_phase  = (m_phase + ref_step(inc_i, int'($signed(mod_i)), wide_mode)) % (1 << PW);
      end
      if (wr_en) begin
         m_tab[wr_addr]   = wr_data;
         m_known[wr_addr] = 1'b1;
      end
   end

   task automatic chk(bit ok, string req, int act, int expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d", req, act, expv);
      end
   endtask

   // every-cycle comparison against the model
   always @(negedge clk) begin
      chk(int'(rd_addr_o) == int'(m_phase >> FW), "R2 R3 address", int'(rd_addr_o), int'(m_phase >> FW));
      if (m_sknown)
         chk(sample_o == m_sample, "R8 sample", int'(sample_o), int'(m_sample));
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         total++;
         bad++;
         $display("FAIL watchdog all act=%0d exp=%0d", cyc, 150000);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   function automatic logic [15:0] ramp(int i);
      return 16'(i * 3 + 7);
   endfunction

   task automatic set_step(int unsigned inc, int modv, bit wide);
      inc_i     = PW'(inc);
      mod_i     = 16'(modv);
      wide_mode = wide;
   endtask

   task automatic wait_n(int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   initial begin
      int a0;
      logic [15:0] oldv;
      for (int i = 0; i < N; i++) m_known[i] = 1'b0;
      // fill the table with a ramp while reset is held (R9 in reset)
      for (int i = 0; i < N; i++) begin
         @(negedge clk);
         wr_en = 1'b1; wr_addr = AW'(i); wr_data = ramp(i);
      end
      @(negedge clk);
      wr_en = 1'b0;
      set_step(32'hFFFFF, 0, 1'b1);
      wait_n(2);
      // R1: reset overrides a large step
      chk(rd_addr_o == '0, "R1 addr in reset", int'(rd_addr_o), 0);
      chk(sample_o == '0, "R1 sample in reset", int'(sample_o), 0);
      rst = 1'b0;
      set_step(32'h0, 0, 1'b0);
      wait_n(2);
      chk(sample_o == ramp(0), "R9 loaded entry 0", int'(sample_o), int'(ramp(0)));

      // R6: narrow cap -> exactly one entry per clock
      a0 = int'(rd_addr_o);
      set_step(32'hFFFFF, 0, 1'b0);
      wait_n(10);
      chk(int'(rd_addr_o) == (a0 + 10) % N, "R6 narrow cap", int'(rd_addr_o), (a0 + 10) % N);
      chk(sample_o == ramp((a0 + 9) % N), "R8 ramp sample", int'(sample_o), int'(ramp((a0 + 9) % N)));

      // R7: wide cap -> half the table per clock
      a0 = int'(rd_addr_o);
      set_step(32'hFFFFF, 1000, 1'b1);
      wait_n(3);
      chk(int'(rd_addr_o) == (a0 + 3 * N / 2) % N, "R7 wide cap", int'(rd_addr_o), (a0 + 3 * N / 2) % N);

      // R2: half-table step twice returns to the start (wrap)
      a0 = int'(rd_addr_o);
      set_step(32'h80000, 0, 1'b1);
      wait_n(2);
      chk(int'(rd_addr_o) == a0, "R2 wrap", int'(rd_addr_o), a0);

      // R4: increment plus positive modulation
      a0 = int'(rd_addr_o);
      set_step(32'h800, 32'h800, 1'b0);
      wait_n(5);
      chk(int'(rd_addr_o) == (a0 + 5) % N, "R4 positive mod", int'(rd_addr_o), (a0 + 5) % N);

      // R4: negative modulation in wide mode, 2 entries per clock
      a0 = int'(rd_addr_o);
      set_step(32'h3000, -32'sh1000, 1'b1);
      wait_n(4);
      chk(int'(rd_addr_o) == (a0 + 8) % N, "R4 negative mod", int'(rd_addr_o), (a0 + 8) % N);

      // R5: negative sum floors at zero, address holds
      a0 = int'(rd_addr_o);
      set_step(100, -5000, 1'b1);
      wait_n(5);
      chk(int'(rd_addr_o) == a0, "R5 floor hold", int'(rd_addr_o), a0);

      // fractional steps, both modes, checked by model every cycle
      set_step(32'h1A3, 7, 1'b0);
      wait_n(300);
      set_step(32'h2B3C5, -32'sh123, 1'b1);
      wait_n(300);

      // R8/R9: write the entry being read, with phase frozen
      set_step(0, 0, 1'b0);
      wait_n(2);
      a0   = int'(rd_addr_o);
      oldv = sample_o;
      chk(oldv == ramp(a0), "R8 frozen read", int'(oldv), int'(ramp(a0)));
      wr_en = 1'b1; wr_addr = AW'(a0); wr_data = 16'hBEEF;
      @(negedge clk);
      wr_en = 1'b0;
      chk(sample_o == oldv, "R8 old data on same-edge write", int'(sample_o), int'(oldv));
      @(negedge clk);
      chk(sample_o == 16'hBEEF, "R9 new data visible", int'(sample_o), 32'hBEEF);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule